// File: doc/BRIEF.md
# VLAN Table Engine

This block keeps the VLAN membership table of a small Ethernet switch and lets software maintain it through a small register port. Each table entry pairs a 12-bit VLAN identifier with a 12-bit filtering-database number, a 6-bit spanning-tree group number and a 2-bit membership code for each of seven ports. A separate bit vector records which spanning-tree groups are valid. A VLAN entry counts as active only while its group is valid.

Software first fills the identifier, data, filter and group registers. It then writes the command register with the start bit set and polls that bit until it reads back 0. The commands are: empty the whole table, load or remove one VLAN entry, search for the next active VLAN above a given identifier, and set or clear one spanning-tree group. Table commands walk the table one slot per clock. The register port has no streaming data, so it is a plain write strobe with an address and a combinational read. No back-pressure applies: a write always lands in the cycle its strobe is high.

Top module: `vtu_ctrl`

## Requirements
- R1: After reset every register reads 0, the table is empty, all spanning-tree groups are invalid and the engine is idle.
- R2: Writing address 0 with bit 15 set and a legal opcode in bits 14:12 starts a command. Bit 15 of address 0 then reads 1 for ENTRIES+1 cycles for table commands (opcodes 1, 3, 4) and for 1 cycle for the group command (opcode 5).
- R3: A write to address 0 while a command is running is ignored. It neither starts a second command nor changes the running one.
- R4: Load (opcode 3 with bit 12 of address 1 set) stores the identifier from address 1 bits 11:0 with the current data, filter and group registers. Loading an identifier that is already present overwrites that entry and uses no new slot.
- R5: Load with bit 12 of address 1 clear removes the entry holding that identifier, if one exists.
- R6: Search (opcode 4) finds the active entry with the smallest identifier above the value in address 1 bits 11:0. On a hit it writes that identifier, valid bit 1, its filter, its group and its membership codes back into the registers.
- R7: A search that starts from 0xFFF returns the lowest active identifier. A search that finds nothing clears only the valid bit of address 1.
- R8: An entry whose group is not valid is skipped by search. Opcode 5 sets or clears the group given by address 1 bits 5:0, according to bit 12 of address 1.
- R9: Flush (opcode 1) removes every VLAN entry. Spanning-tree group validity is left unchanged.
- R10: Loading a new identifier into a full table changes nothing in the table and sets the sticky flag at bit 11 of address 0. Only a flush clears that flag.
- R11: The membership code is 0 unmodified, 1 untagged, 2 tagged, 3 non-member. Address 2 holds ports 0 to 3 at bits 1:0, 5:4, 9:8 and 13:12. Address 3 holds ports 4 to 6 at bits 1:0, 5:4 and 9:8. All other bits of these registers read 0, and address 4 always reads 0. Address 5 holds the filter in bits 11:0 and address 6 holds the group in bits 5:0.
- R12: Registers written while a command runs do not affect that command. They are taken only when the next command starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |

## Verification
The bench builds the engine with ENTRIES=4 and the default 6-bit group number. This makes the table-full case reachable with four loads and gives a five-cycle busy window that can be checked cycle by cycle. The small table also lets one run cover overwrite while full, search wrap-around, and removal followed by a fresh load into the freed slot. The wide group space still lets entries in valid and invalid groups sit side by side.

// File: rtl/vtu_pkg.sv
package vtu_pkg;
  localparam int VID_W = 12;
  localparam int FID_W = 12;
  localparam int SID_W = 6;
  localparam int NPORT = 7;
  localparam int TAG_W = 2;
  localparam int PORTS_PER_REG = 4;

  typedef logic [NPORT-1:0][TAG_W-1:0] tags_t;

  typedef struct packed {
    logic [VID_W-1:0] vid;
    logic [FID_W-1:0] fid;
    logic [SID_W-1:0] sid;
    tags_t            tags;
  } vlan_ent_t;

  localparam logic [2:0] OPC_FLUSH = 3'd1;
  localparam logic [2:0] OPC_VLOAD = 3'd3;
  localparam logic [2:0] OPC_NEXT  = 3'd4;
  localparam logic [2:0] OPC_SLOAD = 3'd5;

  localparam logic [2:0] A_OP   = 3'd0;
  localparam logic [2:0] A_VID  = 3'd1;
  localparam logic [2:0] A_DAT0 = 3'd2;
  localparam logic [2:0] A_DAT1 = 3'd3;
  localparam logic [2:0] A_DAT2 = 3'd4;
  localparam logic [2:0] A_FID  = 3'd5;
  localparam logic [2:0] A_SID  = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DONE, ST_STU} seq_e;
endpackage

// File: rtl/vtu_stu_bits.sv
module vtu_stu_bits #(
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sid,
  input  logic          wr_valid,
  input  logic [SW-1:0] rd_a_sid,
  output logic          rd_a_valid,
  input  logic [SW-1:0] rd_b_sid,
  output logic          rd_b_valid
);
  localparam int DEPTH = 1 << SW;

  logic [DEPTH-1:0] vbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vbits <= '0;
    else if (wr_en) vbits[wr_sid] <= wr_valid;
  end

  assign rd_a_valid = vbits[rd_a_sid];
  assign rd_b_valid = vbits[rd_b_sid];

  // R8: a group write is visible on the next cycle
  p_stu_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_b_sid == wr_sid) |=> (rd_b_sid != $past(wr_sid)) || (rd_b_valid == $past(wr_valid)));
endmodule

// File: rtl/vtu_entry_store.sv
module vtu_entry_store
  import vtu_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  vlan_ent_t     wr_ent,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic [IW-1:0] rd_idx,
  output vlan_ent_t     rd_ent,
  output logic          rd_used
);
  vlan_ent_t        mem [DEPTH];
  logic [DEPTH-1:0] used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0;
    end else begin
      if (wr_en)  used[wr_idx]  <= 1'b1;
      if (clr_en) used[clr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_ent;
  end

  assign rd_ent  = mem[rd_idx];
  assign rd_used = used[rd_idx];

  // R4: a write lands in a free slot or in the slot already holding that identifier
  p_slot_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!used[wr_idx] || mem[wr_idx].vid == wr_ent.vid));

  // R9: write and clear never collide
  p_wr_clr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, clr_en}));
endmodule

// File: rtl/vtu_scan_acc.sv
module vtu_scan_acc
  import vtu_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [IW-1:0]    slot_idx,
  input  logic             slot_used,
  input  logic             slot_active,
  input  logic [VID_W-1:0] slot_vid,
  input  logic [VID_W-1:0] key_vid,
  output logic             hit_m,
  output logic [IW-1:0]    idx_m,
  output logic             hit_f,
  output logic [IW-1:0]    idx_f,
  output logic             hit_b,
  output logic [IW-1:0]    idx_b
);
  logic [VID_W-1:0] best_vid;
  logic             wrap;
  logic             above;

  assign wrap  = (key_vid == {VID_W{1'b1}});
  assign above = wrap || (slot_vid > key_vid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_m <= 1'b0; idx_m <= '0;
      hit_f <= 1'b0; idx_f <= '0;
      hit_b <= 1'b0; idx_b <= '0;
      best_vid <= '0;
    end else if (clear) begin
      hit_m <= 1'b0;
      hit_f <= 1'b0;
      hit_b <= 1'b0;
    end else if (step) begin
      if (slot_used && slot_vid == key_vid && !hit_m) begin
        hit_m <= 1'b1;
        idx_m <= slot_idx;
      end
      if (!slot_used && !hit_f) begin
        hit_f <= 1'b1;
        idx_f <= slot_idx;
      end
      if (slot_active && above && (!hit_b || slot_vid < best_vid)) begin
        hit_b    <= 1'b1;
        idx_b    <= slot_idx;
        best_vid <= slot_vid;
      end
    end
  end

  // R6: a remembered search candidate always lies above the start key
  p_best_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |-> (wrap || best_vid > key_vid));
endmodule

// File: rtl/vtu_ctrl.sv
module vtu_ctrl
  import vtu_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);
  localparam int SLOT_BITS = 4;

  seq_e             state;
  logic [2:0]       opc_r;
  logic             full_r;
  logic [VID_W-1:0] vid_r;
  logic             vvalid_r;
  logic [FID_W-1:0] fid_r;
  logic [SID_W-1:0] sid_r;
  tags_t            tags_r;
  logic [VID_W-1:0] cmd_vid;
  logic             cmd_valid;
  vlan_ent_t        cmd_ent;
  logic [IW-1:0]    scan_idx;

  logic             busy;
  logic             op_write;
  logic             legal_opc;
  logic             start_cmd;
  logic [2:0]       new_opc;

  vlan_ent_t        rd_ent;
  logic             rd_used;
  logic [IW-1:0]    rd_idx;
  logic             wr_en, clr_en;
  logic [IW-1:0]    wr_idx, clr_idx;
  logic             stu_a_valid, stu_b_valid;
  logic             stu_wr;
  logic             hit_m, hit_f, hit_b;
  logic [IW-1:0]    idx_m, idx_f, idx_b;
  logic [15:0]      dat0_view, dat1_view;

  assign busy      = (state != ST_IDLE);
  assign new_opc   = reg_wdata[14:12];
  assign op_write  = reg_we && (reg_addr == A_OP);
  assign legal_opc = (new_opc == OPC_FLUSH) || (new_opc == OPC_VLOAD) ||
                     (new_opc == OPC_NEXT)  || (new_opc == OPC_SLOAD);
  assign start_cmd = op_write && reg_wdata[15] && legal_opc && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      opc_r     <= '0;
      full_r    <= 1'b0;
      vid_r     <= '0;
      vvalid_r  <= 1'b0;
      fid_r     <= '0;
      sid_r     <= '0;
      tags_r    <= '0;
      cmd_vid   <= '0;
      cmd_valid <= 1'b0;
      cmd_ent   <= '0;
      scan_idx  <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_VID: {vvalid_r, vid_r} <= reg_wdata[VID_W:0];
          A_FID: fid_r <= reg_wdata[FID_W-1:0];
          A_SID: sid_r <= reg_wdata[SID_W-1:0];
          default: ;
        endcase
        for (int p = 0; p < NPORT; p++) begin
          if ((reg_addr == A_DAT0 && p < PORTS_PER_REG) ||
              (reg_addr == A_DAT1 && p >= PORTS_PER_REG))
            tags_r[p] <= reg_wdata[(p % PORTS_PER_REG)*SLOT_BITS +: TAG_W];
        end
      end

      case (state)
        ST_IDLE: begin
          if (start_cmd) begin
            opc_r     <= new_opc;
            cmd_vid   <= vid_r;
            cmd_valid <= vvalid_r;
            cmd_ent   <= '{vid: vid_r, fid: fid_r, sid: sid_r, tags: tags_r};
            scan_idx  <= '0;
            state     <= (new_opc == OPC_SLOAD) ? ST_STU : ST_SCAN;
          end
        end
        ST_SCAN: begin
          scan_idx <= scan_idx + 1'b1;
          if (scan_idx == LAST) state <= ST_DONE;
        end
        ST_STU: state <= ST_IDLE;
        ST_DONE: begin
          state <= ST_IDLE;
          if (opc_r == OPC_NEXT) begin
            if (hit_b) begin
              vid_r    <= rd_ent.vid;
              vvalid_r <= 1'b1;
              fid_r    <= rd_ent.fid;
              sid_r    <= rd_ent.sid;
              tags_r   <= rd_ent.tags;
            end else begin
              vvalid_r <= 1'b0;
            end
          end
          if (opc_r == OPC_VLOAD && cmd_valid && !hit_m && !hit_f) full_r <= 1'b1;
          if (opc_r == OPC_FLUSH) full_r <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = (state == ST_DONE) && (opc_r == OPC_VLOAD) && cmd_valid && (hit_m || hit_f);
    wr_idx  = hit_m ? idx_m : idx_f;
    clr_en  = ((state == ST_SCAN) && (opc_r == OPC_FLUSH)) ||
              ((state == ST_DONE) && (opc_r == OPC_VLOAD) && !cmd_valid && hit_m);
    clr_idx = (state == ST_SCAN) ? scan_idx : idx_m;
    rd_idx  = (state == ST_DONE) ? idx_b : scan_idx;
    stu_wr  = (state == ST_STU);
  end

  vtu_entry_store #(.DEPTH(ENTRIES), .IW(IW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(cmd_ent),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .rd_idx(rd_idx), .rd_ent(rd_ent), .rd_used(rd_used)
  );

  vtu_stu_bits #(.SW(SID_W)) stu_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(stu_wr), .wr_sid(cmd_vid[SID_W-1:0]), .wr_valid(cmd_valid),
    .rd_a_sid(rd_ent.sid), .rd_a_valid(stu_a_valid),
    .rd_b_sid(sid_r), .rd_b_valid(stu_b_valid)
  );

  vtu_scan_acc #(.IW(IW)) acc_i (
    .clk(clk), .rst_n(rst_n),
    .clear(start_cmd), .step(state == ST_SCAN),
    .slot_idx(scan_idx), .slot_used(rd_used),
    .slot_active(rd_used && stu_a_valid),
    .slot_vid(rd_ent.vid), .key_vid(cmd_vid),
    .hit_m(hit_m), .idx_m(idx_m),
    .hit_f(hit_f), .idx_f(idx_f),
    .hit_b(hit_b), .idx_b(idx_b)
  );

  always_comb begin
    dat0_view = '0;
    dat1_view = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (p < PORTS_PER_REG) dat0_view[(p % PORTS_PER_REG)*SLOT_BITS +: TAG_W] = tags_r[p];
      else                   dat1_view[(p % PORTS_PER_REG)*SLOT_BITS +: TAG_W] = tags_r[p];
    end
  end

  always_comb begin
    case (reg_addr)
      A_OP:    reg_rdata = {busy, opc_r, full_r, 11'd0};
      A_VID:   reg_rdata = {3'd0, vvalid_r, vid_r};
      A_DAT0:  reg_rdata = dat0_view;
      A_DAT1:  reg_rdata = dat1_view;
      A_FID:   reg_rdata = {{(16-FID_W){1'b0}}, fid_r};
      A_SID:   reg_rdata = {{(16-SID_W){1'b0}}, sid_r};
      default: reg_rdata = '0;
    endcase
  end

  // R2: a legal command write while idle raises busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> busy);

  // R3: command writes during a running command leave it untouched
  p_ignore_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_write) |=> ($stable(opc_r) && $stable(cmd_vid) && $stable(cmd_valid)));

  // R10: full flag is sticky until a flush finishes
  p_full_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full_r && !(state == ST_DONE && opc_r == OPC_FLUSH)) |=> full_r);

  // R8: a search hit always names a valid group
  p_hit_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && opc_r == OPC_NEXT && hit_b) |=> (vvalid_r && stu_b_valid));

  // R7: a search miss clears the valid bit
  p_miss_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && opc_r == OPC_NEXT && !hit_b) |=> !vvalid_r);
endmodule

// File: tb/vtu_ctrl_tb_top.sv
module vtu_ctrl_tb_top;
  localparam int CAP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  always #5 clk = ~clk;

  vtu_ctrl #(.ENTRIES(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  // reference model: register mirror and table contents
  logic [11:0] m_vid = '0;
  logic        m_vv = 1'b0;
  logic [15:0] m_d0 = '0, m_d1 = '0;
  logic [11:0] m_fid = '0;
  logic [5:0]  m_sid = '0;
  logic        m_full = 1'b0;
  logic [63:0] m_stu = '0;
  logic        t_used [CAP];
  logic [11:0] t_vid [CAP];
  logic [11:0] t_fid [CAP];
  logic [5:0]  t_sid [CAP];
  logic [15:0] t_d0 [CAP];
  logic [15:0] t_d1 [CAP];

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
    case (a)
      3'd1: begin m_vid = d[11:0]; m_vv = d[12]; end
      3'd2: m_d0 = d & 16'h3333;
      3'd3: m_d1 = d & 16'h0333;
      3'd5: m_fid = d[11:0];
      3'd6: m_sid = d[5:0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic model_apply(logic [2:0] opc, logic [11:0] s_vid, logic s_vv, logic [11:0] s_fid,
                             logic [5:0] s_sid, logic [15:0] s_d0, logic [15:0] s_d1);
    int match, free, idx, best;
    match = -1; free = -1; best = -1;
    case (opc)
      3'd1: begin
        for (int i = 0; i < CAP; i++) t_used[i] = 1'b0;
        m_full = 1'b0;
      end
      3'd3: begin
        for (int i = 0; i < CAP; i++) begin
          if (t_used[i] && t_vid[i] == s_vid && match < 0) match = i;
          if (!t_used[i] && free < 0) free = i;
        end
        if (s_vv) begin
          idx = (match >= 0) ? match : free;
          if (idx >= 0) begin
            t_used[idx] = 1'b1; t_vid[idx] = s_vid; t_fid[idx] = s_fid;
            t_sid[idx] = s_sid; t_d0[idx] = s_d0; t_d1[idx] = s_d1;
          end else m_full = 1'b1;
        end else if (match >= 0) t_used[match] = 1'b0;
      end
      3'd4: begin
        for (int i = 0; i < CAP; i++) begin
          if (t_used[i] && m_stu[t_sid[i]] && (s_vid == 12'hFFF || t_vid[i] > s_vid))
            if (best < 0 || t_vid[i] < t_vid[best]) best = i;
        end
        if (best >= 0) begin
          m_vid = t_vid[best]; m_vv = 1'b1; m_fid = t_fid[best];
          m_sid = t_sid[best]; m_d0 = t_d0[best]; m_d1 = t_d1[best];
        end else m_vv = 1'b0;
      end
      3'd5: m_stu[s_vid[5:0]] = s_vv;
      default: ;
    endcase
  endtask

  task automatic cmp_regs(string r);
    logic [15:0] v;
    rd(3'd0, v); chk(r, int'(v[15]), 0); chk(r, int'(v[11]), int'(m_full));
    rd(3'd1, v); chk(r, int'(v), int'({3'd0, m_vv, m_vid}));
    rd(3'd2, v); chk(r, int'(v), int'(m_d0));
    rd(3'd3, v); chk(r, int'(v), int'(m_d1));
    rd(3'd4, v); chk(r, int'(v), 0);
    rd(3'd5, v); chk(r, int'(v), int'({4'd0, m_fid}));
    rd(3'd6, v); chk(r, int'(v), int'({10'd0, m_sid}));
  endtask

  // busy is compared against the model on every clock of the command
  task automatic run_op(logic [2:0] opc, string r, bit side_en = 0,
                        logic [2:0] side_a = '0, logic [15:0] side_d = '0);
    logic [11:0] s_vid; logic s_vv; logic [11:0] s_fid; logic [5:0] s_sid;
    logic [15:0] s_d0, s_d1, v;
    int explen;
    s_vid = m_vid; s_vv = m_vv; s_fid = m_fid; s_sid = m_sid; s_d0 = m_d0; s_d1 = m_d1;
    explen = (opc == 3'd5) ? 1 : CAP + 1;
    wr(3'd0, {1'b1, opc, 12'd0});
    for (int i = 0; i <= explen; i++) begin
      if (i == 0 && side_en) begin
        wr(side_a, side_d);
      end else begin
        rd(3'd0, v);
        chk({r, " busy"}, int'(v[15]), (i < explen) ? 1 : 0);
        if (int'(v[15]) != ((i < explen) ? 1 : 0)) break;
      end
    end
    model_apply(opc, s_vid, s_vv, s_fid, s_sid, s_d0, s_d1);
    cmp_regs(r);
  endtask

  task automatic load(logic [11:0] vid, logic valid, logic [11:0] fid, logic [5:0] sid,
                      logic [15:0] d0, logic [15:0] d1, string r);
    wr(3'd1, {3'd0, valid, vid});
    wr(3'd2, d0);
    wr(3'd3, d1);
    wr(3'd5, {4'd0, fid});
    wr(3'd6, {10'd0, sid});
    run_op(3'd3, r);
  endtask

  task automatic next_from(logic [11:0] vid, string r);
    wr(3'd1, {4'd0, vid});
    run_op(3'd4, r);
  endtask

  task automatic stu(logic [5:0] sid, logic valid, string r);
    wr(3'd1, {3'd0, valid, 6'd0, sid});
    run_op(3'd5, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < CAP; i++) t_used[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    cmp_regs("R1");

    stu(6'd1, 1'b1, "R8 R2");
    // R11 unused data bits masked on readback
    load(12'd100, 1'b1, 12'd7, 6'd1, 16'hFFFF & 16'h3210, 16'hF123, "R4 R11");
    load(12'd50, 1'b1, 12'd9, 6'd2, 16'h1111, 16'h0222, "R4");
    next_from(12'hFFF, "R8");
    rd(3'd1, v); chk("R8 inactive group skipped", int'(v[11:0]), 100);
    rd(3'd2, v); chk("R11 port layout reg0", int'(v), 16'h3210);
    rd(3'd3, v); chk("R11 port layout reg1", int'(v), 16'h0123);

    stu(6'd2, 1'b1, "R8");
    next_from(12'hFFF, "R7");
    rd(3'd1, v); chk("R7 wrap to lowest", int'(v), 16'h1032);
    next_from(12'd50, "R6");
    rd(3'd5, v); chk("R6 filter written back", int'(v), 7);
    next_from(12'd100, "R7");
    rd(3'd1, v); chk("R7 miss clears valid", int'(v[12]), 0);

    load(12'd100, 1'b1, 12'hABC, 6'd1, 16'h0000, 16'h0000, "R4");
    next_from(12'd50, "R4");
    rd(3'd5, v); chk("R4 overwrite in place", int'(v), 12'hABC);

    load(12'd50, 1'b0, 12'd0, 6'd0, 16'h0, 16'h0, "R5");
    next_from(12'hFFF, "R5");
    rd(3'd1, v); chk("R5 removed entry gone", int'(v[11:0]), 100);

    load(12'd200, 1'b1, 12'd2, 6'd1, 16'h2222, 16'h0111, "R4");
    load(12'd300, 1'b1, 12'd3, 6'd1, 16'h3333, 16'h0333, "R4");
    load(12'd400, 1'b1, 12'd4, 6'd1, 16'h0123, 16'h0321, "R4");
    load(12'd500, 1'b1, 12'd5, 6'd1, 16'h0, 16'h0, "R10");
    rd(3'd0, v); chk("R10 full flag", int'(v[11]), 1);
    load(12'd300, 1'b1, 12'h333, 6'd1, 16'h1, 16'h2, "R10 R4");
    next_from(12'd400, "R10");
    rd(3'd1, v); chk("R10 new identifier not stored", int'(v[12]), 0);
    next_from(12'd200, "R4");
    rd(3'd5, v); chk("R4 overwrite while full", int'(v), 12'h333);

    // R3: flush command issued during a search is dropped
    wr(3'd1, 16'h0FFF);
    run_op(3'd4, "R3", 1'b1, 3'd0, 16'h9000);
    next_from(12'hFFF, "R3");
    rd(3'd1, v); chk("R3 table survives ignored flush", int'(v), 16'h1064);

    run_op(3'd1, "R9");
    rd(3'd0, v); chk("R10 flush clears flag", int'(v[11]), 0);
    next_from(12'hFFF, "R9");
    rd(3'd1, v); chk("R9 table empty", int'(v[12]), 0);

    // R12: identifier rewritten mid-command is not used
    wr(3'd1, {4'h1, 12'd20});
    wr(3'd2, 16'h2103); wr(3'd3, 16'h0012); wr(3'd5, 16'd8); wr(3'd6, 16'd1);
    run_op(3'd3, "R12", 1'b1, 3'd1, {4'h1, 12'd30});
    next_from(12'hFFF, "R12");
    rd(3'd1, v); chk("R12 command used old identifier", int'(v), {4'h1, 12'd20});
    next_from(12'd20, "R12");
    rd(3'd1, v); chk("R12 late identifier absent", int'(v[12]), 0);

    stu(6'd1, 1'b0, "R8");
    next_from(12'hFFF, "R8");
    rd(3'd1, v); chk("R8 group cleared hides entry", int'(v[12]), 0);
    stu(6'd1, 1'b1, "R9");
    next_from(12'hFFF, "R9");
    rd(3'd1, v); chk("R9 flush left groups alone", int'(v[11:0]), 20);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule